// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block keeps a 32-bit count register that advances by one every `DIV` input clocks and a 32-bit compare register. When the count takes a value equal to compare, a timer interrupt-pending bit is latched. The bit stays high until software writes the compare register. The usual way to schedule the next interrupt is to write compare to "current count plus interval". Because the write also clears the pending bit, the same write acknowledges the interrupt and sets the next deadline.

Software can write either register through two independent write strobes and read either one through a select input. Writing the count register sets a new time base, for example at start-up or to line up several timers. That write also restarts the prescaler, so the next increment arrives a full `DIV` period later. The count wraps modulo 2^32. If compare is written below the current count, the match happens only after the count wraps.

Top module: `cc_timer`

## Requirements
- R1: After reset the count is 0, the pending bit is 0 and the prescaler phase is 0, so the first increment occurs `DIV` clocks after reset is released.
- R2: With no count write, the count increases by exactly one on every `DIV`-th clock edge and holds its value on all other edges.
- R3: The count wraps from 0xFFFFFFFF to 0x00000000. A compare value below the current count is therefore reached only after the wrap, that is after 2^32 − (count − compare) increments.
- R4: When the count register takes a value equal to the compare register, either by increment or by a count write, `timer_irq` goes high on that same edge. The 8-bit `cause_ip` vector carries this bit at position 7, and its other seven bits are always 0.
- R5: A compare write clears the pending bit on that edge. This also holds when a match occurs on the same edge, because the clear takes priority.
- R6: Once set, the pending bit stays high through any number of further increments and count writes, until a compare write clears it.
- R7: A count write loads `cnt_wr_data` on that edge and resets the prescaler phase. The next increment comes `DIV` clocks after the write. A count write on an edge where an increment was due replaces that increment.
- R8: A compare write stores `cmp_wr_data`, and the stored value is read back unchanged.
- R9: `rd_data` returns the count when `rd_sel` is 0 and the compare register when `rd_sel` is 1, combinationally from the current register values. `count_o` always shows the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr_en | input | 1 | Count register write strobe |
| cnt_wr_data | input | 32 | Data for a count write |
| cmp_wr_en | input | 1 | Compare register write strobe |
| cmp_wr_data | input | 32 | Data for a compare write |
| rd_sel | input | 1 | Read select: 0 count, 1 compare |
| rd_data | output | 32 | Selected register value |
| count_o | output | 32 | Current count |
| cause_ip | output | 8 | Pending vector, timer bit at position 7 |
| timer_irq | output | 1 | Timer pending level |

## Verification
Every register write takes effect on the edge that samples it, and `timer_irq` rises on the same edge at which the count takes the matching value. There is no extra cycle of latency. `rd_data` follows that edge combinationally. The bench drives its inputs on the falling edge and runs a behavioural model on the rising edge. It compares every output at the next falling edge, so each result is checked exactly half a cycle after the edge that produced it. Named scenarios then check match timing, wraparound distance, clear priority and write-versus-increment collisions at the cycle the model predicts.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
    typedef enum logic {
        SEL_COUNT   = 1'b0,
        SEL_COMPARE = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/cc_timer_prescaler.sv
module cc_timer_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = $clog2(DIV > 1 ? DIV : 2);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart || st_q.phase == LAST)
            st_d.phase = '0;
        else
            st_d.phase = st_q.phase + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = (st_q.phase == LAST);

    generate
        if (DIV > 1) begin : g_gap
            // R7: after a restart the next tick is a full period away
            assert_restart_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !tick);
            // R2: ticks are never back to back when dividing
            assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/cc_timer_count.sv
module cc_timer_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_q_o,
    output logic [CNT_W-1:0] count_next_o,
    output logic             updated_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } st_t;

    st_t  st_d, st_q;
    logic upd;

    always_comb begin
        st_d = st_q;
        upd  = 1'b0;
        if (wr_en) begin
            st_d.count = wr_data;
            upd        = 1'b1;
        end else if (tick) begin
            st_d.count = st_q.count + CNT_W'(1);
            upd        = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_q_o    = st_q.count;
    assign count_next_o = st_d.count;
    assign updated_o    = upd;

    // R2: no tick and no write leaves the count alone
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick) |=> $stable(count_q_o));
    // R3: a tick adds one, modulo 2^CNT_W
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && tick) |=> count_q_o == $past(count_q_o) + CNT_W'(1));
    // R7: a write lands regardless of a tick
    assert_count_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> count_q_o == $past(wr_data));
endmodule

// File: rtl/cc_timer_pending.sv
module cc_timer_pending #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_updated,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [CNT_W-1:0] cmp_value,
    input  logic             cmp_wr,
    output logic             pend_o
);
    typedef struct packed {
        logic pend;
    } st_t;

    st_t  st_d, st_q;
    logic hit;

    always_comb begin
        st_d = st_q;
        hit  = cnt_updated && (cnt_next == cmp_value);
        if (cmp_wr)   st_d.pend = 1'b0;
        else if (hit) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R5: a compare write always clears, even against a match
    assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !pend_o);
    // R4: a match without a compare write latches
    assert_match_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_updated && cnt_next == cmp_value && !cmp_wr) |=> pend_o);
    // R6: pending is sticky until compare is written
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !cmp_wr) |=> pend_o);
endmodule

// File: rtl/cc_timer.sv
module cc_timer
    import cc_timer_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int DIV        = 4,
    parameter int IP_W       = 8,
    parameter int TIMER_LINE = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic [CNT_W-1:0] count_o,
    output logic [IP_W-1:0]  cause_ip,
    output logic             timer_irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
    } st_t;

    st_t              st_d, st_q;
    logic             tick;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_next;
    logic             count_upd;
    logic             pend;

    cc_timer_prescaler #(.DIV(DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cnt_wr_en),
        .tick    (tick)
    );

    cc_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .wr_en        (cnt_wr_en),
        .wr_data      (cnt_wr_data),
        .count_q_o    (count_q),
        .count_next_o (count_next),
        .updated_o    (count_upd)
    );

    cc_timer_pending #(.CNT_W(CNT_W)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_updated (count_upd),
        .cnt_next    (count_next),
        .cmp_value   (st_q.cmp),
        .cmp_wr      (cmp_wr_en),
        .pend_o      (pend)
    );

    always_comb begin
        st_d = st_q;
        if (cmp_wr_en) st_d.cmp = cmp_wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cause_ip             = '0;
        cause_ip[TIMER_LINE] = pend;
    end

    assign timer_irq = pend;
    assign count_o   = count_q;
    assign rd_data   = (rd_sel_e'(rd_sel) == SEL_COMPARE) ? st_q.cmp : count_q;

    // R8: compare holds the written value
    assert_cmp_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr_en |=> st_q.cmp == $past(cmp_wr_data));
    // R4: only the timer line of the vector is ever set
    assert_vector_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_ip) && (cause_ip[TIMER_LINE] == timer_irq));
endmodule

// File: tb/cc_timer_test.sv
module cc_timer_test;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_wr_en = 1'b0;
    logic [31:0] cnt_wr_data = '0;
    logic        cmp_wr_en = 1'b0;
    logic [31:0] cmp_wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] count_o;
    logic [7:0]  cause_ip;
    logic        timer_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    longint m_cnt = 0;
    longint m_cmp = 0;
    int     m_pre = 0;
    bit     m_pend = 0;

    always #4 clk = ~clk;   // 125 MHz

    cc_timer #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .count_o(count_o),
        .cause_ip(cause_ip), .timer_irq(timer_irq)
    );

    task automatic chk(input string req, input longint got, input longint exp, input string what);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at cycle %0d", req, what, got, exp, cycles);
        end
    endtask

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // reference model, updated on the active edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_pend = 0; m_cmp = 0;
        end else begin
            bit upd;
            longint old_cmp;
            old_cmp = m_cmp;
            upd = 0;
            if (cmp_wr_en) m_cmp = cmp_wr_data;
            if (cnt_wr_en) begin
                m_cnt = cnt_wr_data; m_pre = 0; upd = 1;
            end else if (m_pre == DIV - 1) begin
                m_cnt = (m_cnt + 1) % 64'h1_0000_0000; m_pre = 0; upd = 1;
            end else begin
                m_pre++;
            end
            if (cmp_wr_en) m_pend = 0;
            else if (upd && m_cnt == old_cmp) m_pend = 1;
        end
    end

    // compare every output half a cycle after each edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, count_o, m_cnt, "count_o");
            chk(cur_req, timer_irq, m_pend, "timer_irq");
            chk("R4", cause_ip, m_pend ? 8'h80 : 8'h00, "cause_ip");
            chk("R9", rd_data, rd_sel ? m_cmp : m_cnt, "rd_data");
        end
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary_and_end();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_count(input logic [31:0] v);
        cnt_wr_en = 1'b1; cnt_wr_data = v;
        @(negedge clk);
        cnt_wr_en = 1'b0;
    endtask

    task automatic wr_compare(input logic [31:0] v);
        cmp_wr_en = 1'b1; cmp_wr_data = v;
        @(negedge clk);
        cmp_wr_en = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values, first step after DIV edges
        chk("R1", count_o, 0, "count after reset");
        chk("R1", timer_irq, 0, "pending after reset");
        idle(DIV - 2);
        chk("R1", count_o, 0, "count before first step");
        @(negedge clk);
        chk("R1", count_o, 1, "count at first step");

        cur_req = "R2";
        idle(4 * DIV + 1);

        // R4: match by increment
        cur_req = "R4";
        wr_count(32'd100);
        wr_compare(32'd102);
        idle(2 * DIV);
        chk("R4", timer_irq, 1, "pending after count reached compare");

        // R6: sticky across increments and a count write
        cur_req = "R6";
        idle(3 * DIV);
        wr_count(32'd7);
        idle(DIV);
        chk("R6", timer_irq, 1, "pending held");

        // R5: compare write clears
        cur_req = "R5";
        wr_compare(32'd500);
        chk("R5", timer_irq, 0, "pending cleared by compare write");

        // R8/R9: read back compare
        cur_req = "R8";
        rd_sel = 1'b1;
        @(negedge clk);
        chk("R8", rd_data, 500, "compare readback");
        wr_compare(32'hDEAD_BEEF);
        chk("R8", rd_data, 32'hDEAD_BEEF, "compare readback 2");
        rd_sel = 1'b0;
        @(negedge clk);

        // R4: count write equal to compare sets pending at once
        cur_req = "R4";
        wr_count(32'hDEAD_BEEF);
        chk("R4", timer_irq, 1, "pending on count write match");

        // R5: simultaneous compare write and matching count write
        cur_req = "R5";
        cnt_wr_en = 1'b1; cnt_wr_data = 32'd50;
        cmp_wr_en = 1'b1; cmp_wr_data = 32'd50;
        @(negedge clk);
        cnt_wr_en = 1'b0; cmp_wr_en = 1'b0;
        chk("R5", timer_irq, 0, "clear priority");
        idle(DIV * 3);

        // R7: write on the edge where an increment was due
        cur_req = "R7";
        for (int k = 0; k < DIV; k++) begin
            cnt_wr_en = 1'b1; cnt_wr_data = 32'd1000 + 32'(k);
            idle(k + 1);
            cnt_wr_en = 1'b0;
            chk("R7", count_o, 1000 + k, "count loaded");
            idle(DIV - 1);
            chk("R7", count_o, 1000 + k, "no step before full period");
            @(negedge clk);
            chk("R7", count_o, 1001 + k, "step after full period");
        end

        // R3: compare below count, match only after wrap
        cur_req = "R3";
        wr_compare(32'd5);
        wr_count(32'hFFFF_FFFC);
        idle(DIV * 8);
        chk("R3", timer_irq, 0, "no pending before wrap distance");
        idle(DIV);
        chk("R3", timer_irq, 1, "pending after 9 increments");
        chk("R3", count_o, 5, "count wrapped to compare");

        cur_req = "R2";
        rd_sel = 1'b1;
        idle(3 * DIV);
        summary_and_end();
    end
endmodule